// File: doc/BRIEF.md
# Latched Bidirectional Parity Transceiver

This block moves one byte plus its parity bit between two sides, A and B, in whichever direction the two active-low output enables select. Each side owns a storage stage that is transparent while its enable is high and keeps its last captured byte and parity bit while the enable is low. A parity sense input picks odd or even parity for the whole block. A mode input picks between two behaviours. In generate mode, the parity bit on the outgoing side is recomputed from the source byte. In feed-through mode, the parity bit received with the byte goes out unchanged.

Each side has an active-low error flag. The flag compares the parity computed from that side's stored or transparent byte against that side's own stored or transparent parity bit. Each driven value passes through the storage stage on the destination side. As a result, one transfer checks the parity at both ends. Bidirectional pins appear as separate input, output and drive-enable vectors. If both directions are requested at once, A to B wins and a sticky flag records the conflict.

Top module: `par_xcvr`

## Requirements
- R1: During reset and after it, both storage stages hold an all-zero byte with a parity bit of 0, and contention_o is 0.
- R2: With oe_ab_ni=0 and oe_ba_ni=1, b_oe_o=1 and a_oe_o=0. With oe_ab_ni=1 and oe_ba_ni=0, a_oe_o=1 and b_oe_o=0. With both high, both drive enables are 0.
- R3: With both enables at 0, the A-to-B direction is driven. From the next clock edge on, contention_o is 1, and it stays 1 until reset.
- R4: In generate mode (feed_thru_i=0), the destination parity output is the parity of the source byte. odd_sel_i=1 makes the byte plus the bit hold an odd count of ones. odd_sel_i=0 makes that count even.
- R5: In feed-through mode (feed_thru_i=1), the destination parity output equals the source-side parity bit unchanged.
- R6: While a side's latch enable is 1, its stage is transparent, so the destination data output follows the live source byte in the same cycle.
- R7: While a side's latch enable is 0, its stage outputs the byte and parity captured at the last rising clock edge at which that enable was 1. Changes on the live bus have no effect.
- R8: err_a_no and err_b_no are 0 exactly when the parity computed from that side's stage byte disagrees with that side's stage parity bit. They follow the inputs with no clock delay.
- R9: In generate mode with the destination stage transparent, the value driven to the destination passes back through that stage, so the destination error flag reads 1.
- R10: When a stage is closed, its error flag checks the captured byte and parity, not the live bus.
- R11: The destination data output equals the source stage's byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the storage stages capture on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| odd_sel_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| feed_thru_i | input | 1 | 1 passes the parity bit through, 0 generates it |
| le_a_i | input | 1 | A stage enable, transparent when 1 |
| le_b_i | input | 1 | B stage enable, transparent when 1 |
| oe_ab_ni | input | 1 | Active-low request to drive side B from side A |
| oe_ba_ni | input | 1 | Active-low request to drive side A from side B |
| a_data_i | input | 8 | Byte received on side A |
| a_par_i | input | 1 | Parity bit received on side A |
| b_data_i | input | 8 | Byte received on side B |
| b_par_i | input | 1 | Parity bit received on side B |
| a_data_o | output | 8 | Byte to drive on side A |
| a_par_o | output | 1 | Parity bit to drive on side A |
| a_oe_o | output | 1 | Side A drive enable |
| b_data_o | output | 8 | Byte to drive on side B |
| b_par_o | output | 1 | Parity bit to drive on side B |
| b_oe_o | output | 1 | Side B drive enable |
| err_a_no | output | 1 | Side A parity mismatch, active low |
| err_b_no | output | 1 | Side B parity mismatch, active low |
| contention_o | output | 1 | Sticky flag for a two-direction request |

## Verification
A wrong capture in a closed stage shows up at once on the opposite side's data output, and within the same cycle on that side's error flag. It stays visible until the stage opens again. A wrong parity sense or mode decode changes the destination parity output in the cycle the inputs settle. It also shows up on the destination error flag when that stage is transparent. A contention register that fails to set or to hold shows at the port one clock edge after the conflicting request.

// File: rtl/par_xcvr_pkg.sv
package par_xcvr_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_AB   = 2'd1,
    DIR_BA   = 2'd2
  } dir_e;
endpackage

// File: rtl/xcvr_stage.sv
module xcvr_stage #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] hold_o
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_q <= '0;
    else if (le_i) hold_q <= d_i;
  end

  // transparent view while open, captured value while closed
  assign q_o    = le_i ? d_i : hold_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/par_unit.sv
module par_unit #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              odd_i,
  output logic              gen_o,
  output logic              err_no
);
  logic xor_all;

  assign xor_all = ^data_i;
  assign gen_o   = odd_i ? ~xor_all : xor_all;
  assign err_no  = (gen_o == par_i);
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import par_xcvr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_ab_ni,
  input  logic oe_ba_ni,
  output dir_e dir_o,
  output logic contention_o
);
  logic clash;
  logic contention_q;

  assign clash = !oe_ab_ni && !oe_ba_ni;

  always_comb begin
    if (!oe_ab_ni)      dir_o = DIR_AB;
    else if (!oe_ba_ni) dir_o = DIR_BA;
    else                dir_o = DIR_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    contention_q <= 1'b0;
    else if (clash) contention_q <= 1'b1;
  end

  assign contention_o = contention_q;
endmodule

// File: rtl/par_xcvr.sv
module par_xcvr
  import par_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int LANE_W = DATA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              odd_sel_i,
  input  logic              feed_thru_i,
  input  logic              le_a_i,
  input  logic              le_b_i,
  input  logic              oe_ab_ni,
  input  logic              oe_ba_ni,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic              a_par_i,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic              b_par_i,
  output logic [DATA_W-1:0] a_data_o,
  output logic              a_par_o,
  output logic              a_oe_o,
  output logic [DATA_W-1:0] b_data_o,
  output logic              b_par_o,
  output logic              b_oe_o,
  output logic              err_a_no,
  output logic              err_b_no,
  output logic              contention_o
);
  dir_e dir;

  logic [LANE_W-1:0] a_live, b_live;
  logic [LANE_W-1:0] a_hold, b_hold;
  logic [LANE_W-1:0] a_src, b_src;
  logic [LANE_W-1:0] a_stage_d, b_stage_d;
  logic [LANE_W-1:0] a_view, b_view;
  logic              a_gen, b_gen;
  logic              a_src_err_n, b_src_err_n;

  dir_ctrl i_dir_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .oe_ab_ni     (oe_ab_ni),
    .oe_ba_ni     (oe_ba_ni),
    .dir_o        (dir),
    .contention_o (contention_o)
  );

  assign a_live = {a_data_i, a_par_i};
  assign b_live = {b_data_i, b_par_i};

  // source views use only live inputs and held state, so no path loops back
  assign a_src = le_a_i ? a_live : a_hold;
  assign b_src = le_b_i ? b_live : b_hold;

  par_unit #(.DATA_W(DATA_W)) i_gen_a (
    .data_i (a_src[LANE_W-1:1]),
    .par_i  (a_src[0]),
    .odd_i  (odd_sel_i),
    .gen_o  (a_gen),
    .err_no (a_src_err_n)
  );

  par_unit #(.DATA_W(DATA_W)) i_gen_b (
    .data_i (b_src[LANE_W-1:1]),
    .par_i  (b_src[0]),
    .odd_i  (odd_sel_i),
    .gen_o  (b_gen),
    .err_no (b_src_err_n)
  );

  assign b_data_o = a_src[LANE_W-1:1];
  assign b_par_o  = feed_thru_i ? a_src[0] : a_gen;
  assign a_data_o = b_src[LANE_W-1:1];
  assign a_par_o  = feed_thru_i ? b_src[0] : b_gen;

  assign b_oe_o = (dir == DIR_AB);
  assign a_oe_o = (dir == DIR_BA);

  // a driven side sees its own outgoing value on the pins
  assign a_stage_d = a_oe_o ? {a_data_o, a_par_o} : a_live;
  assign b_stage_d = b_oe_o ? {b_data_o, b_par_o} : b_live;

  xcvr_stage #(.W(LANE_W)) i_stage_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .le_i   (le_a_i),
    .d_i    (a_stage_d),
    .q_o    (a_view),
    .hold_o (a_hold)
  );

  xcvr_stage #(.W(LANE_W)) i_stage_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .le_i   (le_b_i),
    .d_i    (b_stage_d),
    .q_o    (b_view),
    .hold_o (b_hold)
  );

  logic a_chk_gen, b_chk_gen;

  par_unit #(.DATA_W(DATA_W)) i_chk_a (
    .data_i (a_view[LANE_W-1:1]),
    .par_i  (a_view[0]),
    .odd_i  (odd_sel_i),
    .gen_o  (a_chk_gen),
    .err_no (err_a_no)
  );

  par_unit #(.DATA_W(DATA_W)) i_chk_b (
    .data_i (b_view[LANE_W-1:1]),
    .par_i  (b_view[0]),
    .odd_i  (odd_sel_i),
    .gen_o  (b_chk_gen),
    .err_no (err_b_no)
  );

  logic unused_ok;
  assign unused_ok = ^{a_src_err_n, b_src_err_n, a_chk_gen, b_chk_gen};
endmodule

// File: rtl/par_xcvr_chk.sv
module par_xcvr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              odd_sel_i,
  input logic              feed_thru_i,
  input logic              le_a_i,
  input logic              le_b_i,
  input logic              oe_ab_ni,
  input logic              oe_ba_ni,
  input logic [DATA_W-1:0] a_data_i,
  input logic              a_par_i,
  input logic [DATA_W-1:0] b_data_o,
  input logic              b_par_o,
  input logic              a_oe_o,
  input logic              b_oe_o,
  input logic              err_b_no,
  input logic              contention_o
);
  p_one_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({a_oe_o, b_oe_o}));

  p_ab_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ab_ni && !oe_ba_ni) |-> b_oe_o);

  p_flag_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ab_ni && !oe_ba_ni) |=> contention_o);

  p_flag_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    contention_o |=> contention_o);

  p_gen_par_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o && !feed_thru_i) |->
      (b_par_o == (odd_sel_i ? ~(^b_data_o) : (^b_data_o))));

  p_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o && feed_thru_i && le_a_i) |-> (b_par_o == a_par_i));

  p_transp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o && le_a_i) |-> (b_data_o == a_data_i));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_a_i && $past(!le_a_i) && $past(rst_ni)) |-> $stable(b_data_o));

  p_loopback_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o && !feed_thru_i && le_b_i) |-> err_b_no);
endmodule

bind par_xcvr par_xcvr_chk #(.DATA_W(DATA_W)) i_par_xcvr_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .odd_sel_i    (odd_sel_i),
  .feed_thru_i  (feed_thru_i),
  .le_a_i       (le_a_i),
  .le_b_i       (le_b_i),
  .oe_ab_ni     (oe_ab_ni),
  .oe_ba_ni     (oe_ba_ni),
  .a_data_i     (a_data_i),
  .a_par_i      (a_par_i),
  .b_data_o     (b_data_o),
  .b_par_o      (b_par_o),
  .a_oe_o       (a_oe_o),
  .b_oe_o       (b_oe_o),
  .err_b_no     (err_b_no),
  .contention_o (contention_o)
);

// File: tb/test_par_xcvr.sv
module test_par_xcvr;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       odd_sel_i = 1'b0;
  logic       feed_thru_i = 1'b0;
  logic       le_a_i = 1'b0;
  logic       le_b_i = 1'b0;
  logic       oe_ab_ni = 1'b1;
  logic       oe_ba_ni = 1'b1;
  logic [7:0] a_data_i = '0;
  logic       a_par_i = 1'b0;
  logic [7:0] b_data_i = '0;
  logic       b_par_i = 1'b0;
  logic [7:0] a_data_o, b_data_o;
  logic       a_par_o, b_par_o, a_oe_o, b_oe_o;
  logic       err_a_no, err_b_no, contention_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  par_xcvr i_par_xcvr (.*);

  function automatic logic exp_par(input logic [7:0] d, input logic odd);
    return odd ? ~(^d) : (^d);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive on falling edge, sample 2 ns later (before next rising edge)
  task automatic settle();
    @(negedge clk_i);
  endtask

  task automatic look();
    #2;
  endtask

  task automatic t_reset();
    settle(); oe_ab_ni = 1'b0; look();
    check("R1 b data", b_data_o, 8'h00);
    check("R1 b par feed", {feed_thru_i, b_par_o}, 2'b00);
    check("R1 err a", err_a_no, 1);
    check("R1 contention", contention_o, 0);
    settle(); rst_ni = 1'b1; oe_ab_ni = 1'b1; look();
    check("R1 after release", contention_o, 0);
  endtask

  task automatic t_direction();
    settle(); oe_ab_ni = 1'b0; oe_ba_ni = 1'b1; look();
    check("R2 ab", {a_oe_o, b_oe_o}, 2'b01);
    settle(); oe_ab_ni = 1'b1; oe_ba_ni = 1'b0; look();
    check("R2 ba", {a_oe_o, b_oe_o}, 2'b10);
    settle(); oe_ba_ni = 1'b1; look();
    check("R2 none", {a_oe_o, b_oe_o}, 2'b00);
  endtask

  task automatic t_generate();
    logic [7:0] pats [4] = '{8'h00, 8'hA5, 8'h01, 8'h7F};
    feed_thru_i = 1'b0;
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 4; k++) begin
        settle();
        odd_sel_i = s[0]; le_a_i = 1'b1; le_b_i = 1'b1;
        oe_ab_ni = 1'b0; oe_ba_ni = 1'b1;
        a_data_i = pats[k]; a_par_i = ~exp_par(pats[k], s[0]);
        look();
        check("R4 b par", b_par_o, exp_par(pats[k], s[0]));
        check("R11 b data", b_data_o, pats[k]);
        check("R9 err b", err_b_no, 1);
        check("R8 err a bad", err_a_no, 0);
      end
    end
    settle(); oe_ab_ni = 1'b1; oe_ba_ni = 1'b0;
    b_data_i = 8'h3C; odd_sel_i = 1'b1; b_par_i = 1'b0; look();
    check("R4 a par", a_par_o, exp_par(8'h3C, 1'b1));
    check("R11 a data", a_data_o, 8'h3C);
    check("R9 err a", err_a_no, 1);
    oe_ba_ni = 1'b1;
  endtask

  task automatic t_feedthru();
    settle(); feed_thru_i = 1'b1; odd_sel_i = 1'b0;
    le_a_i = 1'b1; le_b_i = 1'b1; oe_ab_ni = 1'b0;
    a_data_i = 8'h81; a_par_i = 1'b1; look();
    check("R5 pass bad", b_par_o, 1);
    check("R8 err b follows", err_b_no, 0);
    settle(); a_par_i = 1'b0; look();
    check("R5 pass good", b_par_o, 0);
    check("R6 transparent", b_data_o, 8'h81);
    check("R8 err b ok", err_b_no, 1);
    settle(); oe_ab_ni = 1'b1; feed_thru_i = 1'b0;
  endtask

  task automatic t_latch();
    settle(); oe_ab_ni = 1'b0; le_a_i = 1'b1; le_b_i = 1'b1; odd_sel_i = 1'b0;
    a_data_i = 8'h5A; a_par_i = 1'b0;
    settle(); le_a_i = 1'b0; a_data_i = 8'hFF; a_par_i = 1'b1; look();
    check("R7 hold data", b_data_o, 8'h5A);
    settle(); a_data_i = 8'h12; look();
    check("R7 hold later", b_data_o, 8'h5A);
    settle(); le_a_i = 1'b1; look();
    check("R6 reopen", b_data_o, 8'h12);
    settle(); oe_ab_ni = 1'b1;
  endtask

  task automatic t_closed_check();
    settle(); odd_sel_i = 1'b0; le_a_i = 1'b1;
    a_data_i = 8'h07; a_par_i = 1'b0; look();
    check("R8 live bad", err_a_no, 0);
    settle(); le_a_i = 1'b0; a_par_i = 1'b1; look();
    check("R10 closed keeps err", err_a_no, 0);
    settle(); le_a_i = 1'b1; look();
    check("R10 reopen clears", err_a_no, 1);
  endtask

  task automatic t_contention();
    settle(); oe_ab_ni = 1'b0; oe_ba_ni = 1'b0; look();
    check("R3 ab wins", {a_oe_o, b_oe_o}, 2'b01);
    check("R3 not yet", contention_o, 0);
    settle(); look();
    check("R3 set", contention_o, 1);
    oe_ab_ni = 1'b1; oe_ba_ni = 1'b1;
    settle(); settle(); look();
    check("R3 sticky", contention_o, 1);
  endtask

  initial begin
    t_reset();
    t_direction();
    t_generate();
    t_feedthru();
    t_latch();
    t_closed_check();
    t_contention();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      if (done) break;
      @(posedge clk_i);
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    #1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule